// File: doc/BRIEF.md
# Write Completion Acknowledge Poller

This block is a master-side sequencer for a serial memory. After a memory write, the memory runs an internal programming cycle and ignores the bus until it finishes. The poller does not wait a fixed worst-case time. It repeatedly sends a start condition and the device select byte with the direction bit at 0 (write). A missing acknowledge means the memory is still busy. The first acknowledged select tells the poller that the memory is ready, and the memory treats that select as the first byte of the next instruction.

A request carries the 7-bit device select, the byte address and the kind of the next operation. It is accepted only while the poller is idle. Once the select is acknowledged, the poller sends the byte address without a new start.
- For a write, it finishes at that point and leaves the bus open so that the data bytes can follow.
- For a random-address read, it issues a repeated start after the address and then finishes, so that a read select can follow.

The poller does the following when things go wrong:
- After each unacknowledged attempt, it sends a stop and stays quiet for a parameterised number of cycles before it retries.
- When the attempt limit is used up, it sends a stop and reports an error.
- When the address byte is not acknowledged, it also sends a stop and reports an error.

The bus engine below the poller handles bit-level timing. The poller talks to it through a byte-level command handshake.

States:
- `S_IDLE`
- `S_START` (start issued)
- `S_SEL` (select byte)
- `S_RETRY_STOP` (stop after a refused select)
- `S_GAP` (quiet wait)
- `S_ADDR` (address byte)
- `S_RESTART` (repeated start for a read)
- `S_FAIL_STOP` (stop before error)
- `S_DONE` (one-cycle success)
- `S_ERR` (one-cycle error)

Transitions:
- IDLE→START on accept.
- START→SEL on command completion.
- SEL→ADDR on acknowledge.
- SEL→RETRY_STOP on a refused select when attempts remain.
- SEL→FAIL_STOP on the last refused select.
- RETRY_STOP→GAP on completion.
- GAP→START on timer expiry.
- ADDR→DONE for a write.
- ADDR→RESTART for a read.
- ADDR→FAIL_STOP on a refused address.
- RESTART→DONE on completion.
- FAIL_STOP→ERR on completion.
- DONE→IDLE and ERR→IDLE unconditionally.

Top module: `wcap_poller`

## Requirements
- R1: After reset, `req_ready` is 1 and `busy`, `cmd_valid`, `done` and `err` are 0.
- R2: A request is taken only in a cycle where `req_ready` is 1. A `req_valid` raised while busy has no effect on the command stream or on the number of `done` pulses.
- R3: Command op codes are START=0, SEND=1, RESTART=2 and STOP=3. Each attempt is a START followed by a SEND whose byte is `{req_dev, 1'b0}`.
- R4: A SEND of the select byte that completes without acknowledge, while attempts remain, is followed by a STOP. After that, `cmd_valid` stays low for exactly GAP_CYCLES cycles, and then a new START follows.
- R5: After an acknowledged select, the next command is a SEND of `req_addr` with no START in between. For a write (`req_read`=0), an acknowledged address ends the request with `done` and no STOP or RESTART.
- R6: For a read (`req_read`=1), an acknowledged address is followed by a RESTART, and then `done`.
- R7: If MAX_TRIES selects in a row are refused, the last one is followed by a STOP and then `err`. No address byte is sent.
- R8: A refused address byte is followed by a STOP and then `err`.
- R9: While `cmd_valid` is 1 and `cmd_done` is 0, `cmd_op` and `cmd_byte` hold steady into the next cycle.
- R10: `done` and `err` are single-cycle pulses that are never high together. `req_ready` is 1 in the cycle after either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Poller is idle and takes the request |
| req_read | input | 1 | Next operation: 1 random-address read, 0 write |
| req_dev | input | DEV_W | Device select bits, without the direction bit |
| req_addr | input | ADDR_W | Byte address of the next operation |
| cmd_valid | output | 1 | A bus command is pending |
| cmd_op | output | 2 | Command code: 0 start, 1 send byte, 2 restart, 3 stop |
| cmd_byte | output | DEV_W+1 | Byte to send with a send command, 0 otherwise |
| cmd_done | input | 1 | One-cycle pulse: the pending command finished |
| cmd_ack | input | 1 | With `cmd_done` on a send: the byte was acknowledged |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse: the request was handed over successfully |
| err | output | 1 | One-cycle pulse: attempt limit hit or address refused |

## Verification
The bench drives the main function with several memory behaviours.
- A memory that acknowledges the first select shows that no retry happens when none is needed.
- Memories that refuse one or two selects before answering show that the STOP, the quiet gap and the repeated attempts are present, and that the gap has the right length.
- A memory that never answers separates a correct attempt limit from an off-by-one limit.
- A refused address byte separates the address error path from the select retry path.

The write and read variants are both run after polling, which shows whether the RESTART appears only for reads. A request offered while the poller is busy shows whether requests are accepted at the wrong time.

// File: rtl/wcap_pkg.sv
package wcap_pkg;

    typedef enum logic [1:0] {
        OP_START   = 2'd0,
        OP_SEND    = 2'd1,
        OP_RESTART = 2'd2,
        OP_STOP    = 2'd3
    } bus_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_SEL,
        S_RETRY_STOP,
        S_GAP,
        S_ADDR,
        S_RESTART,
        S_FAIL_STOP,
        S_DONE,
        S_ERR
    } poll_state_e;

endpackage

// File: rtl/wcap_try_counter.sv
module wcap_try_counter #(
    parameter int MAX_TRIES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last_try
);
    localparam int CW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES + 1) : 1;

    logic [CW-1:0] tries;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tries <= '0;
        end else if (clear) begin
            tries <= '0;
        end else if (bump && !last_try) begin
            tries <= tries + 1'b1;
        end
    end

    assign last_try = (tries == CW'(MAX_TRIES - 1));

    // R7: the attempt count never passes the final allowed attempt
    p_tries_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= CW'(MAX_TRIES - 1));

endmodule

// File: rtl/wcap_gap_timer.sv
module wcap_gap_timer #(
    parameter int GAP_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int TW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES + 1) : 1;

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && (cnt == TW'(GAP_CYCLES - 1));

    // R4: the quiet-cycle count stays inside the configured window
    p_gap_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < TW'(GAP_CYCLES));

endmodule

// File: rtl/wcap_poller.sv
module wcap_poller
    import wcap_pkg::*;
#(
    parameter int DEV_W      = 7,
    parameter int ADDR_W     = 8,
    parameter int MAX_TRIES  = 4,
    parameter int GAP_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_read,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [DEV_W:0]    cmd_byte,
    input  logic              cmd_done,
    input  logic              cmd_ack,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int BYTE_W = DEV_W + 1;

    poll_state_e       state, state_nx;
    logic              kind_read;
    logic [DEV_W-1:0]  dev_q;
    logic [ADDR_W-1:0] addr_q;
    logic              accept;
    logic              sel_refused;
    logic              last_try;
    logic              gap_expire;

    assign accept      = req_valid && (state == S_IDLE);
    assign sel_refused = (state == S_SEL) && cmd_done && !cmd_ack;

    wcap_try_counter #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .bump     (sel_refused),
        .last_try (last_try)
    );

    wcap_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == S_GAP),
        .expire (gap_expire)
    );

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_read <= 1'b0;
            dev_q     <= '0;
            addr_q    <= '0;
        end else if (accept) begin
            kind_read <= req_read;
            dev_q     <= req_dev;
            addr_q    <= req_addr;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:       if (accept) state_nx = S_START;
            S_START:      if (cmd_done) state_nx = S_SEL;
            S_SEL: begin
                if (cmd_done) begin
                    if (cmd_ack)       state_nx = S_ADDR;
                    else if (last_try) state_nx = S_FAIL_STOP;
                    else               state_nx = S_RETRY_STOP;
                end
            end
            S_RETRY_STOP: if (cmd_done) state_nx = S_GAP;
            S_GAP:        if (gap_expire) state_nx = S_START;
            S_ADDR: begin
                if (cmd_done) begin
                    if (!cmd_ack)      state_nx = S_FAIL_STOP;
                    else if (kind_read) state_nx = S_RESTART;
                    else               state_nx = S_DONE;
                end
            end
            S_RESTART:    if (cmd_done) state_nx = S_DONE;
            S_FAIL_STOP:  if (cmd_done) state_nx = S_ERR;
            S_DONE:       state_nx = S_IDLE;
            S_ERR:        state_nx = S_IDLE;
            default:      state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = OP_START;
        cmd_byte  = '0;
        done      = 1'b0;
        err       = 1'b0;
        unique case (state)
            S_START: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_START;
            end
            S_SEL: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_SEND;
                cmd_byte  = {dev_q, 1'b0};
            end
            S_ADDR: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_SEND;
                cmd_byte  = BYTE_W'(addr_q);
            end
            S_RESTART: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_RESTART;
            end
            S_RETRY_STOP, S_FAIL_STOP: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_STOP;
            end
            S_DONE:  done = 1'b1;
            S_ERR:   err  = 1'b1;
            default: ;
        endcase
    end

    assign req_ready = (state == S_IDLE);
    assign busy      = (state != S_IDLE);

    // R9: a pending command is held until the engine finishes it
    p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

    // R10: success and error never coincide, and each is one cycle wide
    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    p_pulse_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> (!done && !err && req_ready));

    // R2: an accepted request starts a START command in the next cycle
    p_accept_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd_valid && cmd_op == OP_START));

    // R4: the end of the quiet wait leads straight into a new START
    p_gap_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gap_expire |=> (cmd_valid && cmd_op == OP_START));

    // R5: an acknowledged select is followed by a SEND with no START between
    p_sel_to_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SEL && cmd_done && cmd_ack) |=> (cmd_valid && cmd_op == OP_SEND));

endmodule

// File: tb/wcap_poller_bench.sv
module wcap_poller_bench;
    localparam int DEV_W  = 7;
    localparam int ADDR_W = 8;
    localparam int MAXT   = 4;
    localparam int GAP    = 3;
    localparam int LAT    = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_read = 1'b0;
    logic [DEV_W-1:0]  req_dev = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              cmd_valid;
    logic [1:0]        cmd_op;
    logic [DEV_W:0]    cmd_byte;
    logic              cmd_done = 1'b0;
    logic              cmd_ack = 1'b0;
    logic              busy, done, err;

    wcap_poller #(.DEV_W(DEV_W), .ADDR_W(ADDR_W), .MAX_TRIES(MAXT), .GAP_CYCLES(GAP)) u_wcap_poller (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_read(req_read), .req_dev(req_dev), .req_addr(req_addr),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
        .cmd_done(cmd_done), .cmd_ack(cmd_ack), .busy(busy), .done(done), .err(err)
    );

    always #5 clk = ~clk;

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;

    // engine model state and command log
    int polls_left = 0;
    bit addr_refuse = 1'b0;
    bit after_start = 1'b0;
    int lat = 0;
    int log_n = 0;
    int log_op [64];
    int log_byte [64];

    // monitors
    int done_cnt = 0;
    int err_cnt = 0;
    int run_len = 0;
    int last_gap = -1;
    int hold_bad = 0;
    logic prev_valid = 1'b0;
    logic prev_done = 1'b0;
    logic [1:0] prev_op = '0;
    logic [DEV_W:0] prev_byte = '0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // byte-level bus engine model
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (cmd_done) begin
                cmd_done = 1'b0;
                cmd_ack  = 1'b0;
                lat      = 0;
            end else if (cmd_valid && rst_n) begin
                lat++;
                if (lat >= LAT) begin
                    lat = 0;
                    if (log_n < 64) begin
                        log_op[log_n]   = int'(cmd_op);
                        log_byte[log_n] = int'(cmd_byte);
                    end
                    log_n++;
                    cmd_ack = 1'b0;
                    if (cmd_op == 2'd1) begin
                        if (after_start) begin
                            cmd_ack = (polls_left == 0);
                            if (polls_left > 0) polls_left--;
                        end else begin
                            cmd_ack = !addr_refuse;
                        end
                    end
                    after_start = (cmd_op == 2'd0);
                    cmd_done = 1'b1;
                end
            end
        end
    end

    // output monitor, sampled mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (done) done_cnt++;
                if (err)  err_cnt++;
                if (prev_valid && !prev_done && !(cmd_valid && cmd_op == prev_op && cmd_byte == prev_byte))
                    hold_bad++;
                if (!busy) run_len = 0;
                else if (!cmd_valid) run_len++;
                else if (!prev_valid && cmd_valid) begin
                    last_gap = run_len;
                    run_len = 0;
                end
            end
            prev_valid = cmd_valid;
            prev_done  = cmd_done;
            prev_op    = cmd_op;
            prev_byte  = cmd_byte;
        end
    end

    task automatic run_req(input bit rd, input int dev, input int addr, input int polls, input bit arefuse);
        int guard;
        polls_left  = polls;
        addr_refuse = arefuse;
        log_n = 0;
        done_cnt = 0;
        err_cnt = 0;
        @(posedge clk);
        #2;
        req_valid = 1'b1;
        req_read  = rd;
        req_dev   = DEV_W'(dev);
        req_addr  = ADDR_W'(addr);
        @(posedge clk);
        #2;
        req_valid = 1'b0;
        guard = 0;
        while (!(done || err) && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic expect_entry(input int i, input int op, input int byt, input string req);
        check(log_op[i] == op, req, $sformatf("op of command %0d", i), log_op[i], op);
        if (op == 1)
            check(log_byte[i] == byt, req, $sformatf("byte of command %0d", i), log_byte[i], byt);
    endtask

    task automatic t_reset;
        check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        check(busy == 1'b0, "R1", "busy", busy, 0);
        check(cmd_valid == 1'b0, "R1", "cmd_valid", cmd_valid, 0);
        check(done == 1'b0 && err == 1'b0, "R1", "done|err", done | err, 0);
    endtask

    task automatic t_write_ready;
        run_req(1'b0, 7'h50, 8'h3C, 0, 1'b0);
        check(log_n == 3, "R5", "command count", log_n, 3);
        expect_entry(0, 0, 0, "R3");
        expect_entry(1, 1, 8'hA0, "R3");
        expect_entry(2, 1, 8'h3C, "R5");
        check(done_cnt == 1 && err_cnt == 0, "R5", "done pulses", done_cnt, 1);
        check(req_ready == 1'b1, "R10", "ready after done", req_ready, 1);
    endtask

    task automatic t_write_polls;
        run_req(1'b0, 7'h51, 8'h07, 2, 1'b0);
        check(log_n == 9, "R4", "command count", log_n, 9);
        expect_entry(2, 3, 0, "R4");
        expect_entry(3, 0, 0, "R4");
        expect_entry(5, 3, 0, "R4");
        expect_entry(6, 0, 0, "R4");
        expect_entry(7, 1, 8'hA2, "R3");
        expect_entry(8, 1, 8'h07, "R5");
        check(last_gap == GAP, "R4", "quiet cycles before retry", last_gap, GAP);
        check(done_cnt == 1, "R10", "single done pulse", done_cnt, 1);
    endtask

    task automatic t_read_poll;
        run_req(1'b1, 7'h52, 8'hF1, 1, 1'b0);
        check(log_n == 7, "R6", "command count", log_n, 7);
        expect_entry(4, 1, 8'hA4, "R3");
        expect_entry(5, 1, 8'hF1, "R6");
        expect_entry(6, 2, 0, "R6");
        check(done_cnt == 1 && err_cnt == 0, "R6", "done pulses", done_cnt, 1);
    endtask

    task automatic t_timeout;
        run_req(1'b0, 7'h53, 8'h11, 100, 1'b0);
        check(log_n == 3 * MAXT, "R7", "command count", log_n, 3 * MAXT);
        expect_entry(3 * MAXT - 2, 1, 8'hA6, "R7");
        expect_entry(3 * MAXT - 1, 3, 0, "R7");
        check(err_cnt == 1 && done_cnt == 0, "R7", "err pulses", err_cnt, 1);
        check(req_ready == 1'b1, "R10", "ready after err", req_ready, 1);
    endtask

    task automatic t_addr_refused;
        run_req(1'b1, 7'h54, 8'h22, 0, 1'b1);
        check(log_n == 4, "R8", "command count", log_n, 4);
        expect_entry(2, 1, 8'h22, "R8");
        expect_entry(3, 3, 0, "R8");
        check(err_cnt == 1 && done_cnt == 0, "R8", "err pulses", err_cnt, 1);
    endtask

    task automatic t_busy_ignore;
        int guard;
        polls_left  = 1;
        addr_refuse = 1'b0;
        log_n = 0;
        done_cnt = 0;
        err_cnt = 0;
        @(posedge clk);
        #2;
        req_valid = 1'b1;
        req_read  = 1'b0;
        req_dev   = 7'h55;
        req_addr  = 8'h40;
        @(posedge clk);
        #2;
        req_addr  = 8'h99;
        req_read  = 1'b1;
        guard = 0;
        while (!(done || err) && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(log_n == 6, "R2", "command count", log_n, 6);
        expect_entry(5, 1, 8'h40, "R2");
        check(done_cnt == 1, "R2", "done pulses", done_cnt, 1);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_ready();
        t_write_polls();
        t_read_poll();
        t_timeout();
        t_addr_refused();
        t_busy_ignore();
        check(hold_bad == 0, "R9", "unstable pending command cycles", hold_bad, 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule